// File: doc/BRIEF.md
# Interrupt Status, Enable and Acknowledge Unit

This unit collects the event sources of a two-wire bus controller into one 32-bit pending word and drives a single level-sensitive interrupt line. It is programmed over a simple register bus. Some sources are FIFO fill levels, and those bits show the live input at every moment. The other sources are one-cycle event pulses. Each pulse sets a sticky pending bit, which stays set until software writes a 1 to that bit position in the acknowledge register.

A programmable enable word selects which pending bits reach the output. Software can read three views of the state: the raw pending word, the enable word, and the enabled (filtered) word. The interrupt line is the OR of the enabled word. Bit positions that carry no source always read as zero and ignore every write.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the enable word, the sticky pending bits and `irq_o` are all zero.
- R2: Raw bits 0, 1, 2, 4, 5 and 6 (TX empty, TX nearly empty, TX full, RX empty, RX nearly full, RX full) equal the matching bits of `lvl_i` in the same cycle.
- R3: Raw bits 3, 16, 17, 18, 19, 20, 24, 25 and 28 are sticky. A high bit of `evt_i` at a rising clock edge sets the bit, and it stays set until it is acknowledged.
- R4: Writing to offset 0x38 clears every sticky bit whose `bus_wdata` bit is 1, starting from the next cycle. Sticky bits whose data bit is 0 keep their value.
- R5: When an event and an acknowledge for the same bit arrive in the same cycle, the bit is left set.
- R6: Writes to offset 0x38 do not change the level bits or any reserved bit, and offset 0x38 reads as zero.
- R7: The enable word is read and written at offset 0x2C. Bits 31:29 always read zero, whatever value was written.
- R8: Offset 0x34 reads the raw word ANDed with the enable word.
- R9: `irq_o` is high exactly when the enabled word is nonzero.
- R10: The raw word is read at offset 0x30. Bits outside 0x131F007F read zero whatever `evt_i` and `lvl_i` carry, and writes to 0x30 and 0x34 change nothing.
- R11: Any offset other than 0x2C, 0x30, 0x34 and 0x38 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_i | input | 32 | Event pulses; only the sticky positions are used |
| lvl_i | input | 32 | FIFO level flags; only the level positions are used |
| irq_o | output | 1 | Interrupt request, level sensitive |

## Verification
A sequence of vectors drives level flags, event pulses, enable words and acknowledge words together. Some vectors drive all ones on every input, which shows that reserved positions never appear. An all-zero enable word shows the pending state while the line stays quiet. Partial acknowledge words separate the sticky bits that clear from the bits that must survive. Directed cases then cover the same-cycle set/clear collision, acknowledges aimed at live level bits, writes to read-only offsets, and reads of unmapped offsets.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int REG_W = 32;

    // Sticky event positions: TX overrun, slave-side requests, master/slave done,
    // arbitration lost, bus error, done-without-stop.
    localparam logic [REG_W-1:0] STICKY_BITS = 32'h131F_0008;
    // Live FIFO level positions.
    localparam logic [REG_W-1:0] LEVEL_BITS  = 32'h0000_0077;
    // Every position that carries a source.
    localparam logic [REG_W-1:0] SOURCE_BITS = STICKY_BITS | LEVEL_BITS;
    // Enable word: top three positions forced low.
    localparam logic [REG_W-1:0] ENABLE_BITS = 32'h1FFF_FFFF;

    localparam logic [7:0] OFF_ENABLE = 8'h2C;
    localparam logic [7:0] OFF_RAW    = 8'h30;
    localparam logic [7:0] OFF_FILT   = 8'h34;
    localparam logic [7:0] OFF_ACK    = 8'h38;

    typedef struct packed {
        logic [REG_W-1:0] pend;
    } pend_state_t;

    typedef struct packed {
        logic [REG_W-1:0] en;
    } enable_state_t;

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
    import irq_status_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP_BITS = STICKY_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] pend_o
);

    pend_state_t st_d, st_q;

    // Set has priority over a clear arriving in the same cycle.
    always_comb begin
        st_d      = st_q;
        st_d.pend = ((st_q.pend & ~clr_i) | set_i) & KEEP_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Only positions named in KEEP_BITS hold a flop; the rest are tied low.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (KEEP_BITS[b]) begin : g_flop
            assign pend_o[b] = st_q.pend[b];
        end else begin : g_tie
            assign pend_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_status_pkg::*;
#(
    parameter logic [REG_W-1:0] WR_BITS = ENABLE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] en_o
);

    enable_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.en = wdata_i & WR_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  raw_i,
    input  logic [REG_W-1:0]  en_i,
    input  logic [REG_W-1:0]  filt_i,
    output logic [REG_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(OFF_FILT);

    // The acknowledge offset and unmapped offsets fall to zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_EN)   rdata_o = en_i;
        if (addr_i == A_RAW)  rdata_o = raw_i;
        if (addr_i == A_FILT) rdata_o = filt_i;
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  evt_i,
    input  logic [REG_W-1:0]  lvl_i,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFF_ACK);

    logic             en_wr;
    logic [REG_W-1:0] ack_vec;
    logic [REG_W-1:0] pend_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] raw_word;
    logic [REG_W-1:0] filt_word;

    always_comb begin
        en_wr   = bus_wr && (bus_addr == A_EN);
        ack_vec = (bus_wr && (bus_addr == A_ACK)) ? bus_wdata : '0;
    end

    irq_pend_latch #(.KEEP_BITS(STICKY_BITS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_i),
        .clr_i  (ack_vec),
        .pend_o (pend_q)
    );

    irq_enable_reg #(.WR_BITS(ENABLE_BITS)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr),
        .wdata_i (bus_wdata),
        .en_o    (en_q)
    );

    always_comb begin
        raw_word  = (lvl_i & LEVEL_BITS) | pend_q;
        filt_word = raw_word & en_q;
        irq_o     = |filt_word;
    end

    irq_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .addr_i  (bus_addr),
        .raw_i   (raw_word),
        .en_i    (en_q),
        .filt_i  (filt_word),
        .rdata_o (bus_rdata)
    );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [REG_W-1:0]  evt_i,
    input logic              irq_o,
    input logic [REG_W-1:0]  pend_q
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(OFF_FILT);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);

    logic ack_wr;
    assign ack_wr = bus_wr && (bus_addr == A_ACK);

    // R3: an event pulse without an acknowledge leaves its bit set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && ((evt_i & STICKY_BITS) != '0)) |=>
        ((pend_q & $past(evt_i & STICKY_BITS)) == $past(evt_i & STICKY_BITS)));

    // R4: acknowledged bits without a new event are clear next cycle
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((pend_q & $past(bus_wdata & ~evt_i)) == '0));

    // R5: event wins over a same-cycle acknowledge
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((pend_q & $past(evt_i & STICKY_BITS)) == $past(evt_i & STICKY_BITS)));

    // R6: acknowledge offset reads zero
    a_r6_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ACK) |-> (bus_rdata == '0));

    // R7: top enable bits never read back
    a_r7_enable_top_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_EN) |-> (bus_rdata[31:29] == 3'b000));

    // R9: line follows the filtered word
    a_r9_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_FILT) |-> (irq_o == (bus_rdata != '0)));

    // R10: reserved raw positions read zero
    a_r10_raw_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_RAW) |-> ((bus_rdata & ~SOURCE_BITS) == '0));

endmodule

bind irq_status_unit irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .pend_q    (pend_q)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   evt_i = '0;
    logic [31:0]   lvl_i = '0;
    logic          irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_status_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .lvl_i(lvl_i), .irq_o(irq_o)
    );

    // lvl, evt pulse, enable write, ack write, expected raw, enable, filtered, irq
    typedef struct packed {
        logic [31:0] lvl;
        logic [31:0] evt;
        logic [31:0] en;
        logic [31:0] ack;
        logic [31:0] x_raw;
        logic [31:0] x_en;
        logic [31:0] x_filt;
        logic        x_irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0011, 32'h0000_0008, 32'h0000_0008, 32'h0000_0000,
          32'h0000_0019, 32'h0000_0008, 32'h0000_0008, 1'b1},
        '{32'h0000_0066, 32'h0100_0000, 32'h0000_0060, 32'h0000_0008,
          32'h0100_0066, 32'h0000_0060, 32'h0000_0060, 1'b1},
        '{32'h0000_0000, 32'h1000_0000, 32'hFFFF_FFFF, 32'h0100_0077,
          32'h1000_0000, 32'h1FFF_FFFF, 32'h1000_0000, 1'b1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000,
          32'h131F_007F, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0200_0000, 32'h011F_0000,
          32'h1200_007F, 32'h0200_0000, 32'h0200_0000, 1'b1},
        '{32'h0000_0000, 32'h0000_0000, 32'h1FFF_FFFF, 32'hFFFF_FFFF,
          32'h0000_0000, 32'h1FFF_FFFF, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h2C, v); check("R1 enable", v, 32'h0);
        rd(8'h30, v); check("R1 raw", v, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);

        // vector walk: R2 R3 R4 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lvl_i = VECS[i].lvl;
            pulse(VECS[i].evt);
            wr(8'h2C, VECS[i].en);
            wr(8'h38, VECS[i].ack);
            rd(8'h30, v); check($sformatf("R2/R3/R4/R10 raw v%0d", i), v, VECS[i].x_raw);
            rd(8'h2C, v); check($sformatf("R7 enable v%0d", i), v, VECS[i].x_en);
            rd(8'h34, v); check($sformatf("R8 filtered v%0d", i), v, VECS[i].x_filt);
            check($sformatf("R9 irq v%0d", i), {31'h0, irq_o}, {31'h0, VECS[i].x_irq});
        end

        // R2 live: level change seen without a clock edge
        @(negedge clk);
        bus_addr = 8'h30;
        lvl_i = 32'h0000_0024;
        #1;
        check("R2 live level", bus_rdata, 32'h0000_0024);
        lvl_i = '0;

        // R5 event and acknowledge of bit 25 in the same cycle
        @(negedge clk);
        evt_i = 32'h0200_0000;
        bus_wr = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h0200_0000;
        @(negedge clk);
        evt_i = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(8'h30, v); check("R5 set wins", v, 32'h0200_0000);
        wr(8'h38, 32'h0200_0000);
        rd(8'h30, v); check("R4 later ack clears", v, 32'h0);

        // R6 acknowledge does not touch level bits; ack offset reads zero
        @(negedge clk);
        lvl_i = 32'h0000_0077;
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h30, v); check("R6 level kept", v, 32'h0000_0077);
        rd(8'h38, v); check("R6 ack reads zero", v, 32'h0);
        lvl_i = '0;

        // R10 writes to raw and filtered offsets ignored
        pulse(32'h0000_0008);
        wr(8'h2C, 32'h0000_0008);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h34, 32'h0000_0000);
        rd(8'h30, v); check("R10 raw write ignored", v, 32'h0000_0008);
        rd(8'h34, v); check("R10 filtered write ignored", v, 32'h0000_0008);
        check("R9 irq after pulse", {31'h0, irq_o}, 32'h1);

        // R11 unmapped offsets
        rd(8'h00, v); check("R11 offset 00", v, 32'h0);
        rd(8'h3C, v); check("R11 offset 3C", v, 32'h0);
        rd(8'h31, v); check("R11 offset 31", v, 32'h0);

        finish_run();
    end

endmodule